// File: doc/BRIEF.md
# Adaptive Memory-Error Correction for a Pipelined Converter

This block sits behind the analog stages of a pipelined converter. On each main sample it takes the signed decisions of the front stages and the code of the final flash stage, and it forms one corrected output word. The word is a weighted sum of the current front-stage decisions and of earlier decisions from the same stages. The weights on earlier decisions cancel the error that one sample leaves behind in the next.

A slow but highly linear reference converter samples the same input once every M main samples. When a reference value arrives, the block subtracts the corrected output of the matching main sample from it. It then moves every weight by a least-mean-squares step: the error, times the decision that the weight multiplies, times a power-of-two step size. Over time this drives the mean-square error toward zero.

Only the first few front stages carry adaptive weights. Any later front stages are added with fixed binary weights, and the flash code is added with unit weight.

Top module: `lms_memcal`

## Requirements
- R1: While reset is held and just after it, `out_code` is 0 and `out_vld` is 0. Every current-decision weight holds its nominal value, and every weight on an earlier decision holds 0. The nominal value for front stage j (0-based) is 2^(GL*(NFR-j)) output LSBs, scaled by 2^FRAC. With the defaults (GL=2, NFR=5, FRAC=8) these are 262144, 65536, 16384, 4096 and 1024 for stages 0 to 4.
- R2: `out_vld` is high exactly in the cycle after a cycle with `dec_vld` high. `out_code` changes only in the cycle after `dec_vld`, and otherwise keeps its value.
- R3: The corrected word is formed from the decisions on `dec_in` and the code on `flash_in`. Each decision is a DW-bit two's-complement value, with stage j at bits [j*DW +: DW]. `flash_in` is unsigned. The word is floor(sum of weight × decision / 2^FRAC), plus fixed-weight later stages, plus `flash_in`. With nominal weights this is 1024*d0 + 256*d1 + 64*d2 + 16*d3 + 4*d4 + flash.
- R4: Calibrated stage s (0-based) owns s+2 weights, for taps k = 0 to s+1. Tap k multiplies that stage's decision from k samples earlier. Weight (s,k) sits at `coef_flat[c*CW +: CW]`, where c = s*(s+3)/2 + k.
- R5: A reference on `ref_in` is taken only when `ref_vld` and `dec_vld` are both high. It belongs to the main sample accepted ALIGN samples earlier (default 2). The error is `ref_in` minus the corrected output of that sample.
- R6: On a taken reference, every weight (s,k) gains floor(e × d × 2^FRAC / 2^mu). Here e is the error, d is the decision of stage s taken k samples before the referenced sample, and mu is `mu_sel`.
- R7: A cycle with `ref_vld` high and `dec_vld` low changes no weight.
- R8: An update that would carry a weight beyond the CW-bit signed range leaves the weight at the nearest limit instead: -2^(CW-1) or 2^(CW-1)-1.
- R9: A corrected word beyond the OW-bit signed range is output at the nearest limit (-8192 or 8191 with defaults).
- R10: The weights change only on cycles that take a reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_vld | input | 1 | A main sample is present on the decision inputs |
| dec_in | input | (NSTG-1)*DW | Signed front-stage decisions, stage 0 in the low bits |
| flash_in | input | FW | Unsigned final flash code |
| ref_vld | input | 1 | A reference value is present |
| ref_in | input | OW | Signed reference value in output LSBs |
| mu_sel | input | 5 | Step size exponent, the right shift applied to each update |
| out_vld | output | 1 | Corrected word is new this cycle |
| out_code | output | OW | Signed corrected word |
| coef_flat | output | NCAL*(NCAL+3)/2*CW | All adaptive weights, packed by index c |

## Verification
The hardest case to reach from the ports is a weight on an earlier decision moving in the opposite direction from the current-decision weight of the same stage. That needs a reference that lands on a sample whose decision differs in sign from the decision one sample earlier. The stimulus sends +1 and then -1 on stage 0, adds two fill samples so the reference lines up with the -1 sample, and gives a small positive error. The test then sends +1 followed by 0, so the output shows the earlier-decision weight acting on its own. Saturation is reached with a zero-shift step and a large negative error on a three-valued decision.

// File: rtl/lms_memcal.sv
`timescale 1ns/1ps
module lms_memcal #(
  parameter int NSTG  = 6,
  parameter int NCAL  = 5,
  parameter int DW    = 3,
  parameter int FW    = 4,
  parameter int GL    = 2,
  parameter int FRAC  = 8,
  parameter int CW    = 24,
  parameter int OW    = 14,
  parameter int ALIGN = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 dec_vld,
  input  logic [(NSTG-1)*DW-1:0]               dec_in,
  input  logic [FW-1:0]                        flash_in,
  input  logic                                 ref_vld,
  input  logic signed [OW-1:0]                 ref_in,
  input  logic [4:0]                           mu_sel,
  output logic                                 out_vld,
  output logic signed [OW-1:0]                 out_code,
  output logic [NCAL*(NCAL+3)/2*CW-1:0]        coef_flat
);
  localparam int NFR   = NSTG - 1;
  localparam int NCOEF = NCAL * (NCAL + 3) / 2;
  localparam int HD    = NCAL + ALIGN;
  localparam int PW    = CW + DW;
  localparam int AW    = CW + DW + 8;
  localparam int EW    = OW + 1;
  localparam int WW    = CW + EW + DW + 2;

  localparam logic signed [WW-1:0] WMAX = {{(WW-CW+1){1'b0}}, {(CW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = ~WMAX;
  localparam logic signed [AW-1:0] YMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = ~YMAX;

  logic signed [DW-1:0] cur  [NFR];
  logic signed [DW-1:0] hist [NCAL][HD];
  logic signed [OW-1:0] yq   [ALIGN];
  logic [NCOEF*PW-1:0]  prod_flat;
  logic signed [AW-1:0] acc, ysum;
  logic signed [EW-1:0] err;
  logic                 upd;

  assign upd = dec_vld & ref_vld;
  assign err = {ref_in[OW-1], ref_in} - {yq[ALIGN-1][OW-1], yq[ALIGN-1]};

  for (genvar j = 0; j < NFR; j++) begin : g_cur
    assign cur[j] = dec_in[j*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NCAL; s++)
        for (int a = 0; a < HD; a++) hist[s][a] <= '0;
    end else if (dec_vld) begin
      for (int s = 0; s < NCAL; s++) begin
        hist[s][0] <= cur[s];
        for (int a = 1; a < HD; a++) hist[s][a] <= hist[s][a-1];
      end
    end
  end

  for (genvar s = 0; s < NCAL; s++) begin : g_s
    for (genvar k = 0; k <= s + 1; k++) begin : g_k
      localparam int C = s * (s + 3) / 2 + k;
      localparam logic signed [CW-1:0] NOM =
        (k == 0) ? (CW'(1) << (FRAC + GL * (NFR - s))) : '0;
      logic signed [CW-1:0] wr, wnx;
      logic signed [DW-1:0] dcur, dref;
      logic signed [PW-1:0] wx, dx;
      logic signed [WW-1:0] ex, dr, wwide, dl, sm;

      if (k == 0) begin : g_now
        assign dcur = cur[s];
      end else begin : g_old
        assign dcur = hist[s][k-1];
      end
      assign dref = hist[s][ALIGN+k-1];

      assign wx = {{(PW-CW){wr[CW-1]}}, wr};
      assign dx = {{(PW-DW){dcur[DW-1]}}, dcur};
      assign prod_flat[C*PW +: PW] = wx * dx;

      assign ex    = {{(WW-EW){err[EW-1]}}, err};
      assign dr    = {{(WW-DW){dref[DW-1]}}, dref};
      assign wwide = {{(WW-CW){wr[CW-1]}}, wr};
      assign dl    = ((ex * dr) <<< FRAC) >>> mu_sel;
      assign sm    = wwide + dl;
      assign wnx   = (sm > WMAX) ? WMAX[CW-1:0] : (sm < WMIN) ? WMIN[CW-1:0] : sm[CW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   wr <= NOM;
        else if (upd) wr <= wnx;
      end
      assign coef_flat[C*CW +: CW] = wr;
    end
  end

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCOEF; c++) acc = acc + $signed(prod_flat[c*PW +: PW]);
    ysum = (acc >>> FRAC) + $signed({{(AW-FW){1'b0}}, flash_in});
    for (int j = NCAL; j < NFR; j++)
      ysum = ysum + ($signed({{(AW-DW){cur[j][DW-1]}}, cur[j]}) <<< (GL * (NFR - j)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ALIGN; i++) yq[i] <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= dec_vld;
      if (dec_vld) begin
        yq[0] <= (ysum > YMAX) ? YMAX[OW-1:0] : (ysum < YMIN) ? YMIN[OW-1:0] : ysum[OW-1:0];
        for (int i = 1; i < ALIGN; i++) yq[i] <= yq[i-1];
      end
    end
  end
  assign out_code = yq[0];

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (out_code == '0 && !out_vld));
  a_r2_vld_follows:  assert property (@(posedge clk) disable iff (!rst_n) dec_vld |=> out_vld);
  a_r2_vld_drops:    assert property (@(posedge clk) disable iff (!rst_n) !dec_vld |=> !out_vld);
  a_r2_out_holds:    assert property (@(posedge clk) disable iff (!rst_n) !dec_vld |=> $stable(out_code));
  a_r10_coef_quiet:  assert property (@(posedge clk) disable iff (!rst_n) !(dec_vld && ref_vld) |=> $stable(coef_flat));
endmodule

// File: tb/lms_memcal_bench.sv
`timescale 1ns/1ps
module lms_memcal_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_vld = 1'b0;
  logic [14:0] dec_in = '0;
  logic [3:0] flash_in = '0;
  logic ref_vld = 1'b0;
  logic signed [13:0] ref_in = '0;
  logic [4:0] mu_sel = '0;
  logic out_vld;
  logic signed [13:0] out_code;
  logic [20*24-1:0] coef_flat;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lms_memcal u_lms_memcal (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_in(dec_in), .flash_in(flash_in),
    .ref_vld(ref_vld), .ref_in(ref_in), .mu_sel(mu_sel),
    .out_vld(out_vld), .out_code(out_code), .coef_flat(coef_flat));

  // decisions d0..d4, flash, expected word (nominal weights)
  localparam int TV [6][7] = '{
    '{ 0,  0,  0,  0,  0,  0,     0},
    '{ 1,  0,  0,  0,  0,  5,  1029},
    '{-3, -3, -3, -3, -3,  0, -4092},
    '{ 2,  2,  2,  2,  2, 15,  2743},
    '{-1,  1, -1,  1, -1,  7,  -813},
    '{ 0, -2,  0,  2,  1,  3,  -473}};

  function automatic int coef(input int idx);
    return int'($signed(coef_flat[idx*24 +: 24]));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int a0, input int a1, input int a2, input int a3, input int a4,
                      input int fl, input bit rv, input int rf, input int mu);
    @(negedge clk);
    dec_in   = {3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
    flash_in = 4'(fl);
    ref_vld  = rv;
    ref_in   = 14'(rf);
    mu_sel   = 5'(mu);
    dec_vld  = 1'b1;
    @(posedge clk);
    #1;
    dec_vld = 1'b0;
    ref_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hold;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 out_code", int'(out_code), 0);
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 w(0,0)", coef(0), 262144);
    chk("R1 w(0,1)", coef(1), 0);
    chk("R1 w(1,0)", coef(2), 65536);
    chk("R1 w(4,0)", coef(14), 1024);
    chk("R1 w(4,5)", coef(19), 0);

    for (int i = 0; i < 6; i++) begin
      send(TV[i][0], TV[i][1], TV[i][2], TV[i][3], TV[i][4], TV[i][5], 1'b0, 0, 0);
      chk("R3 nominal word", int'(out_code), TV[i][6]);
      chk("R2 out_vld high", int'(out_vld), 1);
    end
    hold = int'(out_code);
    @(posedge clk); #1;
    chk("R2 out_vld low", int'(out_vld), 0);
    chk("R2 out_code held", int'(out_code), hold);
    chk("R10 no update without reference", coef(0), 262144);

    @(negedge clk);
    ref_vld = 1'b1; ref_in = 14'sd5000; mu_sel = 5'd0;
    @(posedge clk); #1;
    ref_vld = 1'b0;
    chk("R7 lone reference w(0,0)", coef(0), 262144);
    chk("R7 lone reference w(1,0)", coef(2), 65536);

    // R5 R6: reference two samples after A, e=16, mu=4
    do_reset();
    send(1, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1'b1, 1040, 4);
    chk("R6 w(0,0) step", coef(0), 262400);
    chk("R5 w(0,1) untouched", coef(1), 0);
    chk("R6 w(1,0) untouched", coef(2), 65536);
    send(1, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    chk("R6 adapted word", int'(out_code), 1025);

    // R4: memory tap moves against the current tap
    do_reset();
    send( 1, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send(-1, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send( 0, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send( 0, 0, 0, 0, 0, 0, 1'b1, -1016, 3);
    chk("R4 w(0,0)", coef(0), 261888);
    chk("R4 w(0,1)", coef(1), 256);
    send(1, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    chk("R4 memory term alone", int'(out_code), 1);

    // R8 R9: saturation
    do_reset();
    send(3, 3, 0, 0, 0, 0, 1'b0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1'b1, -8192, 0);
    chk("R8 w(0,0) floor", coef(0), -8388608);
    chk("R8 w(1,0) floor", coef(2), -8388608);
    chk("R8 w(0,1) untouched", coef(1), 0);
    send(-3, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    chk("R9 positive clip", int'(out_code), 8191);
    send(3, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    chk("R9 negative clip", int'(out_code), -8192);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule